// File: doc/BRIEF.md
# Descriptor Ring Ownership Walker

This block steps through a circular list of descriptors in memory for one channel of a DMA engine. Each descriptor takes 8 bytes: a 32-bit control word at the lower address and a 32-bit buffer pointer 4 bytes above it. The walker reads the control word of the current entry. If the entry belongs to hardware, it reads the buffer pointer and passes pointer, byte length, data offset and packet-boundary flags to a separate data mover. It then waits for the mover to report completion. Last, it writes the control word back with ownership returned to software and the complete flag set, and raises a one-cycle interrupt.

Software fills the ring, sets the owner flag on the entries it hands over, and programs the base address and the entry count. When the walker finds an entry that software still holds, it stops there. It reads that same entry again only when a poll tick arrives. The tick comes from a divided poll clock outside the block. A build-time option picks the transmit or the receive form. The two forms differ in how wide the offset field is and in whether the mover's received byte count replaces the length in the write-back.

Top module: `ring_walker`

## Requirements
- R1: After reset, or whenever the walker is idle, `mem_req`, `mv_req` and `irq_desc_done` are low. The first entry to be read is entry 0.
- R2: The control word of entry i is read at `ring_base + 8*i`. Its buffer pointer is read at `ring_base + 8*i + 4`.
- R3: An entry whose owner flag (control bit 31) is 0 starts no transfer. The walker reads the same entry's control word again only after a `poll_tick` pulse.
- R4: For an entry whose owner flag is 1, the mover request carries the buffer pointer on `mv_buf_addr`, control bits 15:0 on `mv_len`, bit 29 on `mv_sop` and bit 28 on `mv_eop`.
- R5: The transmit form (IS_TX=1) puts control bits 27:23 on `mv_offset`. The receive form puts bits 25:23 on `mv_offset[2:0]` and drives zeros on the upper two bits.
- R6: In the transmit form the write-back word is the control word read earlier, with bit 31 cleared and bit 30 set. All other bits are unchanged.
- R7: In the receive form the write-back also replaces bits 15:0 with `mv_rx_len`, as sampled when `mv_done` was high. Bits 29:16 are unchanged.
- R8: `irq_desc_done` is high for exactly one cycle after each write-back is acknowledged, and only then.
- R9: The index steps to 0 after entry `ring_count-1`.
- R10: When `walk_en` falls while a transfer is under way, that entry is still written back. No further entry is started.
- R11: A `chan_clr` pulse returns the walker to idle and the index to 0.
- R12: `mem_req` stays high with a stable address until `mem_ack`. `mv_req` stays high until `mv_done`. The two requests are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| walk_en | input | 1 | Channel enable |
| chan_clr | input | 1 | Synchronous channel reset: go idle, index to 0 |
| poll_tick | input | 1 | Pulse that allows a non-owned entry to be read again |
| ring_base | input | ADDR_W | Byte address of entry 0 |
| ring_count | input | CNT_W | Number of entries in the ring |
| mem_req | output | 1 | Descriptor memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | 32 | Write-back control word |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 32 | Read data |
| mv_req | output | 1 | Transfer request to the data mover |
| mv_buf_addr | output | 32 | Buffer pointer |
| mv_len | output | 16 | Byte length |
| mv_sop | output | 1 | Start-of-packet flag |
| mv_eop | output | 1 | End-of-packet flag |
| mv_offset | output | 5 | Byte offset into the buffer |
| mv_done | input | 1 | Transfer finished |
| mv_rx_len | input | 16 | Received byte count (used by the receive form) |
| irq_desc_done | output | 1 | One-cycle pulse per completed entry |

## Verification
The hardest situation to reach from the ports is a fall of `walk_en` that lands inside a transfer, because the enable matters only for a few cycles of each entry. The bench arms two owned entries and then watches `mv_req` cycle by cycle. It drops the enable in the first cycle a request is seen. It then checks that this entry is written back and that the next owned entry in memory is left untouched. A related check is the index reset. A `chan_clr` is applied while an owned entry waits at index 2, so the walker starts at entry 0 only if the reset worked.

// File: rtl/ring_walker_pkg.sv
package ring_walker_pkg;

   localparam int CTL_W     = 32;
   localparam int CTL_OWN   = 31;
   localparam int CTL_CPL   = 30;
   localparam int CTL_SOP   = 29;
   localparam int CTL_EOP   = 28;
   localparam int OFS_LO    = 23;
   localparam int LEN_W     = 16;
   localparam int OFS_MAX_W = 5;

   typedef enum logic [2:0] {
      WK_IDLE,
      WK_RD_CTL,
      WK_WAIT,
      WK_RD_BUF,
      WK_MOVE,
      WK_WRBACK
   } walk_state_t;

endpackage

// File: rtl/rw_index.sv
module rw_index #(
   parameter int IDX_W = 6,
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             adv,
   input  logic [CNT_W-1:0] count,
   output logic [IDX_W-1:0] idx
);

   logic [CNT_W-1:0] idx_plus;

   assign idx_plus = CNT_W'(idx) + CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx <= '0;
      end else if (clr) begin
         idx <= '0;
      end else if (adv) begin
         if (idx_plus >= count) idx <= '0;
         else                   idx <= IDX_W'(idx_plus);
      end
   end

endmodule

// File: rtl/rw_ctl_codec.sv
module rw_ctl_codec
   import ring_walker_pkg::*;
#(
   parameter bit IS_TX = 1'b1
) (
   input  logic [CTL_W-1:0]     ctl,
   input  logic [LEN_W-1:0]     rx_len,
   output logic                 sop,
   output logic                 eop,
   output logic [LEN_W-1:0]     len,
   output logic [OFS_MAX_W-1:0] ofs,
   output logic [CTL_W-1:0]     wb_word
);

   assign sop = ctl[CTL_SOP];
   assign eop = ctl[CTL_EOP];
   assign len = ctl[LEN_W-1:0];

   generate
      if (IS_TX) begin : g_tx
         logic unused_rx_len;
         assign unused_rx_len = ^rx_len;
         assign ofs     = ctl[OFS_LO+OFS_MAX_W-1:OFS_LO];
         assign wb_word = {1'b0, 1'b1, ctl[CTL_SOP:0]};
      end else begin : g_rx
         assign ofs     = {2'b00, ctl[OFS_LO+2:OFS_LO]};
         assign wb_word = {1'b0, 1'b1, ctl[CTL_SOP:LEN_W], rx_len};
      end
   endgenerate

endmodule

// File: rtl/rw_seq.sv
module rw_seq
   import ring_walker_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic clr,
   input  logic tick,
   input  logic mem_ack,
   input  logic own_now,
   input  logic mv_done,
   output logic mem_req,
   output logic mem_we,
   output logic word_sel,
   output logic mv_req,
   output logic ld_ctl,
   output logic ld_buf,
   output logic ld_rx,
   output logic adv,
   output logic irq
);

   walk_state_t state;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= WK_IDLE;
         irq   <= 1'b0;
      end else begin
         irq <= 1'b0;
         if (clr) begin
            state <= WK_IDLE;
         end else begin
            unique case (state)
               WK_IDLE:   if (enable) state <= WK_RD_CTL;
               WK_RD_CTL: if (mem_ack) state <= own_now ? WK_RD_BUF : WK_WAIT;
               WK_WAIT: begin
                  if (!enable)   state <= WK_IDLE;
                  else if (tick) state <= WK_RD_CTL;
               end
               WK_RD_BUF: if (mem_ack) state <= WK_MOVE;
               WK_MOVE:   if (mv_done) state <= WK_WRBACK;
               WK_WRBACK: begin
                  if (mem_ack) begin
                     irq   <= 1'b1;
                     state <= enable ? WK_RD_CTL : WK_IDLE;
                  end
               end
               default:   state <= WK_IDLE;
            endcase
         end
      end
   end

   assign mem_req  = (state == WK_RD_CTL) || (state == WK_RD_BUF) || (state == WK_WRBACK);
   assign mem_we   = (state == WK_WRBACK);
   assign word_sel = (state == WK_RD_BUF);
   assign mv_req   = (state == WK_MOVE);
   assign ld_ctl   = (state == WK_RD_CTL) && mem_ack;
   assign ld_buf   = (state == WK_RD_BUF) && mem_ack;
   assign ld_rx    = (state == WK_MOVE) && mv_done;
   assign adv      = (state == WK_WRBACK) && mem_ack && !clr;

endmodule

// File: rtl/ring_walker.sv
module ring_walker
   import ring_walker_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int MAX_DESC = 64,
   parameter bit IS_TX    = 1'b1,
   parameter int CNT_W    = $clog2(MAX_DESC + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 walk_en,
   input  logic                 chan_clr,
   input  logic                 poll_tick,
   input  logic [ADDR_W-1:0]    ring_base,
   input  logic [CNT_W-1:0]     ring_count,
   output logic                 mem_req,
   output logic                 mem_we,
   output logic [ADDR_W-1:0]    mem_addr,
   output logic [CTL_W-1:0]     mem_wdata,
   input  logic                 mem_ack,
   input  logic [CTL_W-1:0]     mem_rdata,
   output logic                 mv_req,
   output logic [31:0]          mv_buf_addr,
   output logic [LEN_W-1:0]     mv_len,
   output logic                 mv_sop,
   output logic                 mv_eop,
   output logic [OFS_MAX_W-1:0] mv_offset,
   input  logic                 mv_done,
   input  logic [LEN_W-1:0]     mv_rx_len,
   output logic                 irq_desc_done
);

   localparam int IDX_W     = $clog2(MAX_DESC);
   localparam int DESC_SH   = 3;
   localparam int PTR_OFS   = 4;

   generate
      if (MAX_DESC < 2) begin : g_bad_depth
         $error("ring_walker: MAX_DESC must be at least 2");
      end
      if (ADDR_W < IDX_W + DESC_SH) begin : g_bad_addr
         $error("ring_walker: ADDR_W too narrow for the ring");
      end
      if (CNT_W < $clog2(MAX_DESC + 1)) begin : g_bad_cnt
         $error("ring_walker: CNT_W cannot hold MAX_DESC");
      end
   endgenerate

   logic [IDX_W-1:0] idx;
   logic             word_sel, ld_ctl, ld_buf, ld_rx, adv;
   logic [CTL_W-1:0] ctl_q;
   logic [31:0]      buf_q;
   logic [LEN_W-1:0] rx_q;
   logic [CTL_W-1:0] wb_word;

   rw_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (walk_en),
      .clr      (chan_clr),
      .tick     (poll_tick),
      .mem_ack  (mem_ack),
      .own_now  (mem_rdata[CTL_OWN]),
      .mv_done  (mv_done),
      .mem_req  (mem_req),
      .mem_we   (mem_we),
      .word_sel (word_sel),
      .mv_req   (mv_req),
      .ld_ctl   (ld_ctl),
      .ld_buf   (ld_buf),
      .ld_rx    (ld_rx),
      .adv      (adv),
      .irq      (irq_desc_done)
   );

   rw_index #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_index (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (chan_clr),
      .adv   (adv),
      .count (ring_count),
      .idx   (idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
         buf_q <= '0;
         rx_q  <= '0;
      end else begin
         if (ld_ctl) ctl_q <= mem_rdata;
         if (ld_buf) buf_q <= mem_rdata;
         if (ld_rx)  rx_q  <= mv_rx_len;
      end
   end

   rw_ctl_codec #(.IS_TX(IS_TX)) u_codec (
      .ctl     (ctl_q),
      .rx_len  (rx_q),
      .sop     (mv_sop),
      .eop     (mv_eop),
      .len     (mv_len),
      .ofs     (mv_offset),
      .wb_word (wb_word)
   );

   assign mem_addr    = ring_base + (ADDR_W'(idx) << DESC_SH)
                      + (word_sel ? ADDR_W'(PTR_OFS) : ADDR_W'(0));
   assign mem_wdata   = wb_word;
   assign mv_buf_addr = buf_q;

endmodule

// File: rtl/rw_checker.sv
module rw_checker #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              chan_clr,
   input logic              mem_req,
   input logic              mem_we,
   input logic              mem_ack,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [31:0]       mem_wdata,
   input logic              mv_req,
   input logic              mv_done,
   input logic              irq_desc_done
);

   AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_desc_done |=> !irq_desc_done) else $error("irq wider than one cycle"); // R8

   AST_IRQ_AFTER_WB: assert property (@(posedge clk) disable iff (!rst_n)
      irq_desc_done |-> $past(mem_req && mem_we && mem_ack)) else $error("irq without write-back"); // R8

   AST_WB_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (!mem_wdata[31] && mem_wdata[30])) else $error("write-back keeps ownership"); // R6

   AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack && !chan_clr) |=> (mem_req && $stable(mem_addr))) else $error("memory request dropped"); // R12

   AST_MV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mv_req && !mv_done && !chan_clr) |=> mv_req) else $error("mover request dropped"); // R12

   AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_req && mv_req)) else $error("both requests high"); // R12

endmodule

bind ring_walker rw_checker #(.ADDR_W(ADDR_W)) u_rw_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .chan_clr      (chan_clr),
   .mem_req       (mem_req),
   .mem_we        (mem_we),
   .mem_ack       (mem_ack),
   .mem_addr      (mem_addr),
   .mem_wdata     (mem_wdata),
   .mv_req        (mv_req),
   .mv_done       (mv_done),
   .irq_desc_done (irq_desc_done)
);

// File: tb/ring_walker_bench.sv
module rw_bench_mem (
   input  logic        clk,
   input  logic        req,
   input  logic        we,
   input  logic [31:0] addr,
   input  logic [31:0] wdata,
   output logic        ack,
   output logic [31:0] rdata
);
   logic [31:0] mem [0:31];
   initial begin
      ack = 1'b0;
      rdata = '0;
      for (int i = 0; i < 32; i++) mem[i] = '0;
   end
   always @(posedge clk) begin
      ack <= req && !ack;
      if (req && !ack && we) mem[addr[6:2]] <= wdata;
      rdata <= mem[addr[6:2]];
   end
endmodule

module rw_bench_mover (
   input  logic        clk,
   input  logic        req,
   input  logic [31:0] addr,
   output logic        done,
   output logic [15:0] rx_len
);
   int cnt;
   initial begin
      done = 1'b0;
      rx_len = '0;
      cnt = 0;
   end
   always @(posedge clk) begin
      if (req && !done) begin
         cnt <= cnt + 1;
         if (cnt == 1) begin
            done   <= 1'b1;
            rx_len <= addr[15:0] + 16'd3;
            cnt    <= 0;
         end
      end else begin
         done <= 1'b0;
      end
   end
endmodule

module ring_walker_bench;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n = 1'b0;
   int   n_checks = 0;
   int   n_errors = 0;
   bit   finished = 0;

   // transmit instance signals
   logic        t_en = 0, t_clr = 0, t_tick = 0;
   logic [31:0] t_base = 32'h20;
   logic [6:0]  t_count = 7'd4;
   logic        t_mreq, t_mwe, t_mack, t_mvreq, t_mvdone, t_irq, t_sop, t_eop;
   logic [31:0] t_maddr, t_mwdata, t_mrdata, t_bufaddr;
   logic [15:0] t_len, t_rxlen;
   logic [4:0]  t_ofs;

   // receive instance signals
   logic        r_en = 0;
   logic        r_mreq, r_mwe, r_mack, r_mvreq, r_mvdone, r_irq, r_sop, r_eop;
   logic [31:0] r_maddr, r_mwdata, r_mrdata, r_bufaddr;
   logic [15:0] r_len, r_rxlen;
   logic [4:0]  r_ofs;

   ring_walker #(.IS_TX(1'b1)) u_ring_walker (
      .clk(clk), .rst_n(rst_n), .walk_en(t_en), .chan_clr(t_clr), .poll_tick(t_tick),
      .ring_base(t_base), .ring_count(t_count),
      .mem_req(t_mreq), .mem_we(t_mwe), .mem_addr(t_maddr), .mem_wdata(t_mwdata),
      .mem_ack(t_mack), .mem_rdata(t_mrdata),
      .mv_req(t_mvreq), .mv_buf_addr(t_bufaddr), .mv_len(t_len), .mv_sop(t_sop),
      .mv_eop(t_eop), .mv_offset(t_ofs), .mv_done(t_mvdone), .mv_rx_len(t_rxlen),
      .irq_desc_done(t_irq));

   rw_bench_mem   u_mem_tx (.clk(clk), .req(t_mreq), .we(t_mwe), .addr(t_maddr),
                            .wdata(t_mwdata), .ack(t_mack), .rdata(t_mrdata));
   rw_bench_mover u_mv_tx  (.clk(clk), .req(t_mvreq), .addr(t_bufaddr),
                            .done(t_mvdone), .rx_len(t_rxlen));

   ring_walker #(.IS_TX(1'b0)) u_ring_walker_rx (
      .clk(clk), .rst_n(rst_n), .walk_en(r_en), .chan_clr(1'b0), .poll_tick(1'b0),
      .ring_base(32'h0), .ring_count(7'd2),
      .mem_req(r_mreq), .mem_we(r_mwe), .mem_addr(r_maddr), .mem_wdata(r_mwdata),
      .mem_ack(r_mack), .mem_rdata(r_mrdata),
      .mv_req(r_mvreq), .mv_buf_addr(r_bufaddr), .mv_len(r_len), .mv_sop(r_sop),
      .mv_eop(r_eop), .mv_offset(r_ofs), .mv_done(r_mvdone), .mv_rx_len(r_rxlen),
      .irq_desc_done(r_irq));

   rw_bench_mem   u_mem_rx (.clk(clk), .req(r_mreq), .we(r_mwe), .addr(r_maddr),
                            .wdata(r_mwdata), .ack(r_mack), .rdata(r_mrdata));
   rw_bench_mover u_mv_rx  (.clk(clk), .req(r_mvreq), .addr(r_bufaddr),
                            .done(r_mvdone), .rx_len(r_rxlen));

   // monitors
   int          mv_cnt = 0, done_cnt = 0, irq_cnt = 0, d2_reads = 0;
   logic        mvreq_d = 0;
   logic [31:0] log_addr [0:15];
   logic [15:0] log_len  [0:15];
   logic        log_sop  [0:15];
   logic        log_eop  [0:15];
   logic [4:0]  log_ofs  [0:15];
   int          r_mv_cnt = 0, r_irq_cnt = 0;
   logic        r_mvreq_d = 0;
   logic [4:0]  r_log_ofs = '0;

   always @(posedge clk) begin
      mvreq_d   <= t_mvreq;
      r_mvreq_d <= r_mvreq;
      if (rst_n) begin
         if (t_mvreq && !mvreq_d && mv_cnt < 16) begin
            log_addr[mv_cnt] <= t_bufaddr;
            log_len[mv_cnt]  <= t_len;
            log_sop[mv_cnt]  <= t_sop;
            log_eop[mv_cnt]  <= t_eop;
            log_ofs[mv_cnt]  <= t_ofs;
            mv_cnt <= mv_cnt + 1;
         end
         if (t_mvdone) done_cnt <= done_cnt + 1;
         if (t_irq) irq_cnt <= irq_cnt + 1;
         if (t_mreq && t_mack && !t_mwe && t_maddr == 32'h30) d2_reads <= d2_reads + 1;
         if (r_mvreq && !r_mvreq_d) begin
            r_mv_cnt  <= r_mv_cnt + 1;
            r_log_ofs <= r_ofs;
         end
         if (r_irq) r_irq_cnt <= r_irq_cnt + 1;
      end
   end

   function automatic logic [31:0] mk_ctl(input logic own, input logic sop, input logic eop,
                                          input logic [4:0] ofs, input logic [15:0] len);
      return {own, 1'b0, sop, eop, ofs, 7'h15, len};
   endfunction

   function automatic logic [31:0] wb_tx(input logic [31:0] c);
      return {2'b01, c[29:0]};
   endfunction

   function automatic logic [31:0] buf_of(input int i);
      return 32'h1000_0040 + 32'(i) * 32'h100;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      finish_run();
   end

   logic [31:0] c0, c1, c2, c3, c0b, rx0;

   initial begin
      cycles(4);
      rst_n = 1'b1;
      cycles(2);
      // R1 reset state
      chk(!t_mreq && !t_mvreq && !t_irq, "R1", {29'd0, t_mreq, t_mvreq, t_irq}, 32'd0);

      // ring of 4 at byte 0x20 (words 8..15)
      c0 = mk_ctl(1, 1, 0, 5'd5,  16'h0040);
      c1 = mk_ctl(1, 0, 1, 5'd31, 16'h0007);
      c2 = mk_ctl(0, 1, 1, 5'd2,  16'h0100);
      c3 = mk_ctl(0, 0, 0, 5'd9,  16'h0033);
      u_mem_tx.mem[8]  = c0; u_mem_tx.mem[9]  = buf_of(0);
      u_mem_tx.mem[10] = c1; u_mem_tx.mem[11] = buf_of(1);
      u_mem_tx.mem[12] = c2; u_mem_tx.mem[13] = buf_of(2);
      u_mem_tx.mem[14] = c3; u_mem_tx.mem[15] = buf_of(3);
      // receive ring: entry 0 owned, offset field 10110, entry 1 free
      rx0 = mk_ctl(1, 1, 1, 5'b10110, 16'h0020);
      u_mem_rx.mem[0] = rx0; u_mem_rx.mem[1] = 32'h0000_2000;
      t_en = 1;
      r_en = 1;
      cycles(100);

      chk(mv_cnt == 2, "R4 two owned entries moved", 32'(mv_cnt), 32'd2);
      chk(log_addr[0] == buf_of(0), "R2 R4 pointer entry 0", log_addr[0], buf_of(0));
      chk(log_len[0] == 16'h0040 && log_sop[0] && !log_eop[0], "R4 len/flags entry 0",
          {log_sop[0], log_eop[0], 14'd0, log_len[0]}, {2'b10, 14'd0, 16'h0040});
      chk(log_ofs[0] == 5'd5, "R5 tx offset entry 0", 32'(log_ofs[0]), 32'd5);
      chk(log_addr[1] == buf_of(1) && log_len[1] == 16'h7 && !log_sop[1] && log_eop[1],
          "R2 R4 entry 1", log_addr[1], buf_of(1));
      chk(log_ofs[1] == 5'd31, "R5 tx offset 31", 32'(log_ofs[1]), 32'd31);
      chk(u_mem_tx.mem[8] == wb_tx(c0), "R6 write-back entry 0", u_mem_tx.mem[8], wb_tx(c0));
      chk(u_mem_tx.mem[10] == wb_tx(c1), "R6 write-back entry 1", u_mem_tx.mem[10], wb_tx(c1));
      chk(irq_cnt == 2, "R8 one pulse per entry", 32'(irq_cnt), 32'd2);
      chk(u_mem_tx.mem[12] == c2 && d2_reads == 1, "R3 non-owned untouched", u_mem_tx.mem[12], c2);
      chk(r_log_ofs == 5'b00110 && r_mv_cnt == 1, "R5 rx offset 3 bits", 32'(r_log_ofs), 32'd6);
      chk(u_mem_rx.mem[0] == {2'b01, rx0[29:16], 16'h2003}, "R7 rx length write-back",
          u_mem_rx.mem[0], {2'b01, rx0[29:16], 16'h2003});
      chk(r_irq_cnt == 1, "R8 rx pulse", 32'(r_irq_cnt), 32'd1);

      // R3 handing over without a tick does nothing
      c2[31] = 1'b1;
      u_mem_tx.mem[12] = c2;
      cycles(40);
      chk(mv_cnt == 2 && d2_reads == 1, "R3 waits for poll tick", 32'(mv_cnt), 32'd2);
      t_tick = 1; cycles(1); t_tick = 0;
      cycles(100);
      chk(d2_reads == 2 && mv_cnt == 3, "R3 re-read after tick", 32'(d2_reads), 32'd2);
      chk(u_mem_tx.mem[12] == wb_tx(c2), "R6 write-back entry 2", u_mem_tx.mem[12], wb_tx(c2));

      // R9 wrap: entry 3 then entry 0
      c3[31] = 1'b1;
      u_mem_tx.mem[14] = c3;
      c0b = mk_ctl(1, 0, 0, 5'd1, 16'h0011);
      u_mem_tx.mem[8] = c0b;
      t_tick = 1; cycles(1); t_tick = 0;
      cycles(150);
      chk(mv_cnt == 5, "R9 two more entries", 32'(mv_cnt), 32'd5);
      chk(log_addr[3] == buf_of(3), "R2 entry 3 pointer", log_addr[3], buf_of(3));
      chk(log_addr[4] == buf_of(0) && log_len[4] == 16'h0011, "R9 wrap to entry 0",
          log_addr[4], buf_of(0));
      chk(irq_cnt == 5, "R8 pulse count", 32'(irq_cnt), 32'd5);

      // R10 disable mid-transfer: entries 1 and 2 owned
      c1 = mk_ctl(1, 1, 1, 5'd3, 16'h0022);
      c2 = mk_ctl(1, 0, 1, 5'd4, 16'h0044);
      u_mem_tx.mem[10] = c1;
      u_mem_tx.mem[12] = c2;
      t_tick = 1; cycles(1); t_tick = 0;
      for (int k = 0; k < 200 && !t_mvreq; k++) cycles(1);
      t_en = 0;
      cycles(100);
      chk(mv_cnt == 6, "R10 only current entry", 32'(mv_cnt), 32'd6);
      chk(u_mem_tx.mem[10] == wb_tx(c1), "R10 current entry written back", u_mem_tx.mem[10], wb_tx(c1));
      chk(u_mem_tx.mem[12] == c2, "R10 next entry untouched", u_mem_tx.mem[12], c2);
      chk(!t_mreq && !t_mvreq, "R1 idle after disable", {30'd0, t_mreq, t_mvreq}, 32'd0);

      // R11 channel clear returns to entry 0 (entry 2 is still owned)
      t_clr = 1; cycles(1); t_clr = 0;
      c0 = mk_ctl(1, 1, 0, 5'd7, 16'h0055);
      u_mem_tx.mem[8] = c0;
      t_en = 1;
      cycles(100);
      chk(mv_cnt == 7 && log_addr[6] == buf_of(0), "R11 restart at entry 0", log_addr[6], buf_of(0));
      chk(u_mem_tx.mem[12] == c2, "R11 entry 2 not reached", u_mem_tx.mem[12], c2);
      chk(irq_cnt == 7, "R8 total pulses", 32'(irq_cnt), 32'd7);
      chk(done_cnt == mv_cnt, "R12 each request answered once", 32'(done_cnt), 32'(mv_cnt));

      finish_run();
   end

endmodule